// File: doc/BRIEF.md
# Multicore Interrupt and Barrier Controller

This controller sits beside a group of cores and handles the flow-control events that cross core boundaries. Each core brings a one-cycle request with a kind code and a 32-bit operand. The kinds are a software interrupt, an interrupt to another core, wait-for-interrupt, the all-core barrier, return-from-interrupt, interrupt enable and interrupt disable. For each core the block returns three things: a redirect with a new PC, a link-save strobe carrying the value the core writes into its link register R31, and a stall level.

Vector addresses are formed as `VEC_BASE + VEC_STRIDE * n`. Each core has its own combinational read port into the vector table, and the word read through it becomes the redirect PC. The controller keeps three pieces of state per core: an interrupt enable bit, a single pending flag for core-to-core interrupts, and a wait flag. A shared barrier register records which cores have arrived at the barrier. Every core also sees a constant number that identifies it.

Top module: `mcore_irq_ctl`

## Requirements
- R1: A software interrupt (kind 0) is taken whether or not interrupts are enabled. On the next cycle it raises `rd_valid` with `rd_pc` equal to the vector word at `VEC_BASE + VEC_STRIDE*(arg mod NSWI)`, and raises `lk_save` with `lk_val` equal to the requesting core's `core_pc`.
- R2: Return-from-interrupt (kind 4) raises `rd_valid` on the next cycle with `rd_pc` equal to the request's `arg`, and it sets that core's enable.
- R3: Each enable is 1 after reset. Enable request (kind 5) sets it, disable request (kind 6) clears it, and taking any interrupt clears it.
- R4: A core-to-core interrupt (kind 1) targets the core numbered by `arg[4:0]` and sets that core's pending flag. A target number of `NCORE` or above has no effect.
- R5: A pending flag is delivered only when its core is enabled, is not waiting at the barrier, and has no accepted request in that cycle. Delivery redirects the core to vector 0 on the next cycle with link value `core_pc` and clears the flag. Any number of requests made while the flag is set produce one delivery.
- R6: Wait-for-interrupt (kind 2) raises `lk_save` with `core_pc` on the next cycle and holds `stall` high. `stall` falls in the same cycle that the waking delivery raises `rd_valid`.
- R7: Barrier entry (kind 3) holds `stall` high from the next cycle on. In the cycle after the last of the `NCORE` cores arrives, every core's stall falls together.
- R8: A request from a core whose `stall` is high is ignored.
- R9: `core_num` slice c reads c.
- R10: After reset no redirect, link strobe or stall is active and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORE | Per-core request strobe |
| req_kind | input | 3*NCORE | Per-core request kind code |
| req_arg | input | 32*NCORE | Per-core operand: interrupt number, target core or return PC |
| core_pc | input | 32*NCORE | Per-core resume PC, used as the link value |
| vec_addr | output | 32*NCORE | Per-core vector table read address |
| vec_data | input | 32*NCORE | Per-core vector table read data, same cycle |
| rd_valid | output | NCORE | Redirect strobe |
| rd_pc | output | 32*NCORE | Redirect target PC |
| lk_save | output | NCORE | Link register write strobe |
| lk_val | output | 32*NCORE | Value to write into R31 |
| stall | output | NCORE | Core must hold |
| core_num | output | 5*NCORE | Constant number of each core |

## Verification
The bench instantiates three cores. With three cores the barrier count is not a power of two, and core-to-core targets 3 to 31 exercise the out-of-range path. The number of software vectors stays at four, so an interrupt argument of 6 checks that the number wraps modulo the vector count. Directed sequences cover vector addresses, a wait that is woken by another core, interrupts held pending while a core is disabled or at the barrier, and release of the barrier. A random phase with periodic resets then compares every output against a behavioural model on every cycle.

// File: rtl/mcirq_pkg.sv
package mcirq_pkg;
    localparam int ADDR_W = 32;
    localparam int ID_W   = 5;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_SWI  = 3'd0,
        K_XINT = 3'd1,
        K_WAIT = 3'd2,
        K_BAR  = 3'd3,
        K_RET  = 3'd4,
        K_ENA  = 3'd5,
        K_DIS  = 3'd6
    } req_kind_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] pc;
    } redir_t;

    function automatic logic [ADDR_W-1:0] vector_word_addr(
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] stride,
        input logic [ADDR_W-1:0] num);
        return base + stride * num;
    endfunction
endpackage

// File: rtl/mcirq_slot.sv
module mcirq_slot import mcirq_pkg::*; #(
    parameter int                NSWI       = 4,
    parameter logic [ADDR_W-1:0] VEC_BASE   = 32'd1000,
    parameter logic [ADDR_W-1:0] VEC_STRIDE = 32'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [ADDR_W-1:0] req_arg,
    input  logic [ADDR_W-1:0] core_pc,
    input  logic [ADDR_W-1:0] vec_data,
    input  logic              xint_hit,
    input  logic              bar_wait,
    output logic [ADDR_W-1:0] vec_addr,
    output redir_t            rd,
    output redir_t            lk,
    output logic              stall,
    output logic              bar_arrive,
    output logic              xint_fire,
    output logic [ID_W-1:0]   xint_tgt
);
    localparam int SW_W = (NSWI > 1) ? $clog2(NSWI) : 1;

    logic      ien_q, pend_q, wait_q;
    logic      acc, take_sw, take_pend;
    req_kind_e kind;
    logic [SW_W-1:0] sw_num;

    assign kind      = req_kind_e'(req_kind);
    assign stall     = bar_wait | wait_q;
    assign acc       = req_valid & ~stall;
    assign take_sw   = acc && (kind == K_SWI);
    assign take_pend = ~acc & ien_q & pend_q & ~bar_wait;
    assign sw_num    = req_arg[SW_W-1:0];

    assign vec_addr   = vector_word_addr(VEC_BASE, VEC_STRIDE,
                                         take_sw ? ADDR_W'(sw_num) : '0);
    assign bar_arrive = acc && (kind == K_BAR);
    assign xint_fire  = acc && (kind == K_XINT);
    assign xint_tgt   = req_arg[ID_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= 1'b1;
            pend_q <= 1'b0;
            wait_q <= 1'b0;
            rd     <= '0;
            lk     <= '0;
        end else begin
            rd.valid <= 1'b0;
            lk.valid <= 1'b0;
            pend_q   <= (pend_q & ~take_pend) | xint_hit;
            if (acc) begin
                case (kind)
                    K_SWI: begin
                        rd     <= '{valid: 1'b1, pc: vec_data};
                        lk     <= '{valid: 1'b1, pc: core_pc};
                        ien_q  <= 1'b0;
                    end
                    K_RET: begin
                        rd     <= '{valid: 1'b1, pc: req_arg};
                        ien_q  <= 1'b1;
                    end
                    K_ENA:  ien_q <= 1'b1;
                    K_DIS:  ien_q <= 1'b0;
                    K_WAIT: begin
                        lk     <= '{valid: 1'b1, pc: core_pc};
                        wait_q <= 1'b1;
                    end
                    default: ;
                endcase
            end else if (take_pend) begin
                rd     <= '{valid: 1'b1, pc: vec_data};
                lk     <= '{valid: 1'b1, pc: core_pc};
                ien_q  <= 1'b0;
                wait_q <= 1'b0;
            end
        end
    end

    a_r1_swi_entry: assert property (@(posedge clk) disable iff (rst)
        (acc && kind == K_SWI) |=> (rd.valid && lk.valid && !ien_q && lk.pc == $past(core_pc)));

    a_r2_return: assert property (@(posedge clk) disable iff (rst)
        (acc && kind == K_RET) |=> (rd.valid && ien_q && rd.pc == $past(req_arg)));

    a_r5_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        (!ien_q && pend_q && !acc) |=> pend_q);

    a_r6_wait_stalls: assert property (@(posedge clk) disable iff (rst)
        (acc && kind == K_WAIT) |=> stall);

    a_r6_wake_redirects: assert property (@(posedge clk) disable iff (rst)
        $fell(wait_q) |-> rd.valid);

    a_r8_stalled_quiet: assert property (@(posedge clk) disable iff (rst)
        (stall && !ien_q && !pend_q) |=> !rd.valid);
endmodule

// File: rtl/mcirq_barrier.sv
module mcirq_barrier #(
    parameter int NCORE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCORE-1:0] arrive,
    output logic [NCORE-1:0] waiting
);
    logic all_in;
    assign all_in = &waiting;

    always_ff @(posedge clk) begin
        if (rst)         waiting <= '0;
        else if (all_in) waiting <= '0;
        else             waiting <= waiting | arrive;
    end

    a_r7_release_together: assert property (@(posedge clk) disable iff (rst)
        all_in |=> (waiting == '0));

    a_r7_hold_until_all: assert property (@(posedge clk) disable iff (rst)
        (!all_in) |=> ((waiting & $past(waiting)) == $past(waiting)));
endmodule

// File: rtl/mcore_irq_ctl.sv
module mcore_irq_ctl import mcirq_pkg::*; #(
    parameter int                NCORE      = 4,
    parameter int                NSWI       = 4,
    parameter logic [ADDR_W-1:0] VEC_BASE   = 32'd1000,
    parameter logic [ADDR_W-1:0] VEC_STRIDE = 32'd4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NCORE-1:0]          req_valid,
    input  logic [NCORE*KIND_W-1:0]   req_kind,
    input  logic [NCORE*ADDR_W-1:0]   req_arg,
    input  logic [NCORE*ADDR_W-1:0]   core_pc,
    output logic [NCORE*ADDR_W-1:0]   vec_addr,
    input  logic [NCORE*ADDR_W-1:0]   vec_data,
    output logic [NCORE-1:0]          rd_valid,
    output logic [NCORE*ADDR_W-1:0]   rd_pc,
    output logic [NCORE-1:0]          lk_save,
    output logic [NCORE*ADDR_W-1:0]   lk_val,
    output logic [NCORE-1:0]          stall,
    output logic [NCORE*ID_W-1:0]     core_num
);
    logic [NCORE-1:0]           hit, fire, arrive, bar_wait;
    logic [NCORE-1:0][ID_W-1:0] tgt;

    always_comb begin
        hit = '0;
        for (int s = 0; s < NCORE; s++)
            for (int t = 0; t < NCORE; t++)
                if (fire[s] && tgt[s] == ID_W'(t)) hit[t] = 1'b1;
    end

    mcirq_barrier #(.NCORE(NCORE)) u_bar (
        .clk(clk), .rst(rst), .arrive(arrive), .waiting(bar_wait));

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        redir_t rd_s, lk_s;

        mcirq_slot #(.NSWI(NSWI), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .req_valid (req_valid[c]),
            .req_kind  (req_kind[c*KIND_W +: KIND_W]),
            .req_arg   (req_arg[c*ADDR_W +: ADDR_W]),
            .core_pc   (core_pc[c*ADDR_W +: ADDR_W]),
            .vec_data  (vec_data[c*ADDR_W +: ADDR_W]),
            .xint_hit  (hit[c]),
            .bar_wait  (bar_wait[c]),
            .vec_addr  (vec_addr[c*ADDR_W +: ADDR_W]),
            .rd        (rd_s),
            .lk        (lk_s),
            .stall     (stall[c]),
            .bar_arrive(arrive[c]),
            .xint_fire (fire[c]),
            .xint_tgt  (tgt[c])
        );

        assign rd_valid[c]                = rd_s.valid;
        assign rd_pc[c*ADDR_W +: ADDR_W]  = rd_s.pc;
        assign lk_save[c]                 = lk_s.valid;
        assign lk_val[c*ADDR_W +: ADDR_W] = lk_s.pc;
        assign core_num[c*ID_W +: ID_W]   = ID_W'(c);
    end

    a_r4_hit_from_fire: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |-> (fire != '0));
endmodule

// File: tb/mcore_irq_ctl_bench.sv
`timescale 1ns/1ps
module mcore_irq_ctl_bench;
    localparam int NC = 3;
    localparam int KSWI = 0, KXINT = 1, KWAIT = 2, KBAR = 3, KRET = 4, KENA = 5, KDIS = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [NC-1:0]    req_valid, rd_valid, lk_save, stall;
    logic [NC*3-1:0]  req_kind;
    logic [NC*32-1:0] req_arg, core_pc, vec_addr, vec_data, rd_pc, lk_val;
    logic [NC*5-1:0]  core_num;

    bit        v_valid[NC];
    int        v_kind[NC];
    logic [31:0] v_arg[NC], v_pc[NC];

    function automatic logic [31:0] vm(input logic [31:0] a);
        return a * 32'd3 + 32'h77;
    endfunction

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            req_valid[c]         = v_valid[c];
            req_kind[c*3 +: 3]   = 3'(v_kind[c]);
            req_arg[c*32 +: 32]  = v_arg[c];
            core_pc[c*32 +: 32]  = v_pc[c];
            vec_data[c*32 +: 32] = vm(vec_addr[c*32 +: 32]);
        end
    end

    mcore_irq_ctl #(.NCORE(NC)) u_mcore_irq_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_arg(req_arg), .core_pc(core_pc), .vec_addr(vec_addr), .vec_data(vec_data),
        .rd_valid(rd_valid), .rd_pc(rd_pc), .lk_save(lk_save), .lk_val(lk_val),
        .stall(stall), .core_num(core_num));

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit          m_ien[NC], m_pend[NC], m_wfi[NC], m_bar[NC];
    bit          e_rv[NC], e_ls[NC];
    logic [31:0] e_rpc[NC], e_lv[NC];
    bit          m_acc[NC], m_hit[NC], m_arr[NC];
    bit          m_all;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NC; c++) begin
                m_ien[c] = 1; m_pend[c] = 0; m_wfi[c] = 0; m_bar[c] = 0;
                e_rv[c] = 0; e_ls[c] = 0;
            end
        end else begin
            m_all = 1;
            for (int c = 0; c < NC; c++) begin
                if (!m_bar[c]) m_all = 0;
                m_acc[c] = v_valid[c] && !(m_bar[c] || m_wfi[c]);
                m_hit[c] = 0;
                m_arr[c] = 0;
            end
            for (int c = 0; c < NC; c++)
                if (m_acc[c] && v_kind[c] == KXINT && int'(v_arg[c][4:0]) < NC)
                    m_hit[int'(v_arg[c][4:0])] = 1;
            for (int c = 0; c < NC; c++) begin
                e_rv[c] = 0; e_ls[c] = 0;
                if (m_acc[c]) begin
                    case (v_kind[c])
                        KSWI: begin
                            e_rv[c] = 1; e_rpc[c] = vm(32'd1000 + 32'd4 * (v_arg[c] % 4));
                            e_ls[c] = 1; e_lv[c] = v_pc[c]; m_ien[c] = 0;
                        end
                        KRET: begin e_rv[c] = 1; e_rpc[c] = v_arg[c]; m_ien[c] = 1; end
                        KENA: m_ien[c] = 1;
                        KDIS: m_ien[c] = 0;
                        KWAIT: begin e_ls[c] = 1; e_lv[c] = v_pc[c]; m_wfi[c] = 1; end
                        KBAR: m_arr[c] = 1;
                        default: ;
                    endcase
                end else if (m_ien[c] && m_pend[c] && !m_bar[c]) begin
                    e_rv[c] = 1; e_rpc[c] = vm(32'd1000);
                    e_ls[c] = 1; e_lv[c] = v_pc[c];
                    m_ien[c] = 0; m_pend[c] = 0; m_wfi[c] = 0;
                end
                if (m_hit[c]) m_pend[c] = 1;
            end
            for (int c = 0; c < NC; c++)
                m_bar[c] = m_all ? 0 : (m_bar[c] | m_arr[c]);
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            for (int c = 0; c < NC; c++) begin
                chk(rd_valid[c] == e_rv[c], $sformatf("R2 redirect strobe core %0d", c), 32'(rd_valid[c]), 32'(e_rv[c]));
                if (e_rv[c])
                    chk(rd_pc[c*32 +: 32] == e_rpc[c], $sformatf("R1 redirect pc core %0d", c), rd_pc[c*32 +: 32], e_rpc[c]);
                chk(lk_save[c] == e_ls[c], $sformatf("R6 link strobe core %0d", c), 32'(lk_save[c]), 32'(e_ls[c]));
                if (e_ls[c])
                    chk(lk_val[c*32 +: 32] == e_lv[c], $sformatf("R6 link value core %0d", c), lk_val[c*32 +: 32], e_lv[c]);
                chk(stall[c] == (m_bar[c] | m_wfi[c]), $sformatf("R7 stall core %0d", c), 32'(stall[c]), 32'(m_bar[c] | m_wfi[c]));
            end
        end
    end

    task automatic issue(input int c, input int k, input logic [31:0] arg, input logic [31:0] pc);
        v_valid[c] = 1; v_kind[c] = k; v_arg[c] = arg; v_pc[c] = pc;
        @(negedge clk);
        v_valid[c] = 0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1;
        for (int c = 0; c < NC; c++) begin v_valid[c] = 0; v_kind[c] = 0; v_arg[c] = 0; v_pc[c] = 0; end
        step(3);
        rst = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R10 reset state, R9 numbering
        chk(rd_valid == '0 && lk_save == '0 && stall == '0, "R10 outputs idle", 32'({rd_valid, lk_save, stall}), 0);
        for (int c = 0; c < NC; c++)
            chk(core_num[c*5 +: 5] == 5'(c), "R9 core number", 32'(core_num[c*5 +: 5]), c);

        // R1 vectors for each number, R2 return
        for (int n = 0; n < 4; n++) begin
            issue(0, KSWI, n, 32'h100 + n);
            chk(rd_valid[0] && rd_pc[31:0] == vm(1000 + 4 * n), "R1 vector word", rd_pc[31:0], vm(1000 + 4 * n));
            chk(lk_val[31:0] == 32'h100 + n, "R1 link pc", lk_val[31:0], 32'h100 + n);
            issue(0, KRET, 32'h200 + n, 32'h0);
            chk(rd_valid[0] && rd_pc[31:0] == 32'h200 + n, "R2 return pc", rd_pc[31:0], 32'h200 + n);
        end
        issue(0, KSWI, 6, 32'h150);
        chk(rd_pc[31:0] == vm(1008), "R1 number wraps", rd_pc[31:0], vm(1008));
        issue(0, KRET, 32'h250, 0);

        // R3 enabled after reset, R4 delivery; entry clears enable
        issue(0, KXINT, 1, 0);
        step(1);
        chk(rd_valid[1] && rd_pc[63:32] == vm(1000), "R4 xint delivered", rd_pc[63:32], vm(1000));
        issue(0, KXINT, 1, 0);
        step(2);
        chk(!rd_valid[1], "R3 enable cleared by entry", 32'(rd_valid[1]), 0);
        issue(1, KRET, 32'h600, 0);
        chk(rd_pc[63:32] == 32'h600, "R2 return core1", rd_pc[63:32], 32'h600);
        step(1);
        chk(rd_valid[1] && rd_pc[63:32] == vm(1000), "R3 pending after reti", 32'(rd_valid[1]), 1);
        issue(1, KRET, 32'h610, 0);

        // R5 held while disabled, collapse
        issue(1, KDIS, 0, 0);
        issue(2, KXINT, 1, 0);
        step(3);
        chk(!rd_valid[1], "R5 held while disabled", 32'(rd_valid[1]), 0);
        issue(2, KXINT, 1, 0);
        step(2);
        issue(1, KENA, 0, 32'h700);
        step(1);
        chk(rd_valid[1] && lk_val[63:32] == 32'h700, "R5 delivered on enable", lk_val[63:32], 32'h700);
        issue(1, KRET, 32'h710, 0);
        for (int i = 0; i < 3; i++) begin
            step(1);
            chk(!rd_valid[1], "R5 requests collapse", 32'(rd_valid[1]), 0);
        end

        // R3 software interrupt while disabled still taken
        issue(0, KDIS, 0, 0);
        issue(0, KSWI, 3, 32'h180);
        chk(rd_valid[0] && rd_pc[31:0] == vm(1012), "R3 swi ignores enable", rd_pc[31:0], vm(1012));
        issue(0, KRET, 32'h280, 0);

        // R6 wait woken by another core, R8 ignore while stalled
        issue(0, KWAIT, 0, 32'h300);
        chk(lk_save[0] && lk_val[31:0] == 32'h300 && stall[0], "R6 wait links and stalls", lk_val[31:0], 32'h300);
        step(3);
        chk(stall[0], "R6 still waiting", 32'(stall[0]), 1);
        issue(0, KSWI, 1, 32'h300);
        chk(!rd_valid[0] && stall[0], "R8 request while stalled", 32'(rd_valid[0]), 0);
        issue(2, KXINT, 0, 0);
        step(1);
        chk(rd_valid[0] && !stall[0] && lk_val[31:0] == 32'h300, "R6 woken by xint", 32'(stall[0]), 0);
        issue(0, KRET, 32'h304, 0);

        // R4 out-of-range target
        issue(1, KXINT, 5, 0);
        step(3);
        chk(rd_valid == '0, "R4 target out of range", 32'(rd_valid), 0);

        // R7 barrier, R5 held during barrier
        issue(2, KBAR, 0, 32'h900);
        chk(stall[2], "R7 stall after arrival", 32'(stall[2]), 1);
        step(2);
        issue(0, KBAR, 0, 0);
        issue(1, KXINT, 2, 0);
        step(2);
        chk(stall[0] && stall[2] && !stall[1] && !rd_valid[2], "R5 held at barrier", 32'(stall), 32'b101);
        issue(1, KBAR, 0, 0);
        chk(stall == '1, "R7 all waiting", 32'(stall), 32'b111);
        step(1);
        chk(stall == '0, "R7 released together", 32'(stall), 0);
        step(1);
        chk(rd_valid[2] && lk_val[95:64] == 32'h900, "R5 delivered after barrier", 32'(rd_valid[2]), 1);
        issue(2, KRET, 32'h904, 0);

        // random traffic against the model
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc % 400 == 0) do_reset();
            for (int c = 0; c < NC; c++) begin
                v_valid[c] = ($urandom_range(0, 3) == 0);
                v_kind[c]  = $urandom_range(0, 6);
                v_arg[c]   = (v_kind[c] == KRET) ? $urandom() : $urandom_range(0, 7);
                v_pc[c]    = $urandom();
            end
            @(negedge clk);
        end
        for (int c = 0; c < NC; c++) v_valid[c] = 0;
        step(2);
        finish_run();
    end
endmodule